// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block owns the stack pointer of an 8-bit processor core and turns a single stack request into a timed series of memory accesses. The core raises one request bit for a subroutine call, a subroutine return, an interrupt entry, an interrupt return, or one of four single-byte transfers: push or pull the accumulator, push or pull the status byte. The sequencer then issues one memory write or read per cycle. It forms the 16-bit address from the 8-bit pointer and a page-select bit, and it hands popped bytes back to the core with load strobes.

An interrupt entry stores three bytes and then signals two more steps. It pulses a request to set the interrupt-disable flag, then pulses a request for the vector read. A software-break entry marks the stored status byte with its break bit. Memory is treated as combinational on reads: `mem_rdata` answers the address presented in the same cycle.

States: `ST_IDLE` accepts a request. The write states are `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_PUSH_ST` and `ST_PUSH_A`. The read states are `ST_POP_ST`, `ST_POP_LO`, `ST_POP_HI` and `ST_POP_A`. The two pulse states are `ST_SET_I` and `ST_VECTOR`. Transitions:

| From | To |
|---|---|
| `ST_IDLE`, on call or interrupt entry | `ST_PUSH_HI` |
| `ST_IDLE`, on return | `ST_POP_LO` |
| `ST_IDLE`, on interrupt return or pull-status | `ST_POP_ST` |
| `ST_IDLE`, on push-accumulator | `ST_PUSH_A` |
| `ST_IDLE`, on push-status | `ST_PUSH_ST` |
| `ST_IDLE`, on pull-accumulator | `ST_POP_A` |
| `ST_PUSH_HI` | `ST_PUSH_LO` |
| `ST_PUSH_LO` | `ST_PUSH_ST` for an interrupt entry, otherwise `ST_IDLE` |
| `ST_PUSH_ST` | `ST_SET_I` for an interrupt entry, otherwise `ST_IDLE` |
| `ST_SET_I` | `ST_VECTOR` |
| `ST_VECTOR` | `ST_IDLE` |
| `ST_POP_ST` | `ST_POP_LO` for an interrupt return, otherwise `ST_IDLE` |
| `ST_POP_LO` | `ST_POP_HI` |
| `ST_POP_HI`, `ST_POP_A`, `ST_PUSH_A` | `ST_IDLE` |

Top module: `stack_seq`

## Requirements
- R1: A synchronous reset sets the pointer to 0xFF. Out of reset, `busy` is low and no write, read or pulse strobe is active.
- R2: The upper address byte is 0x00 when `page_sel` is 0 and 0x01 when it is 1. The low byte is the pointer for a write and the pointer plus one for a read.
- R3: A call writes PC[15:8] at the pointer address, then PC[7:0] at the decremented address. The pointer ends two lower.
- R4: A return reads the pointer+1 address, then the pointer+2 address. The pointer ends two higher. In the second read cycle `pc_load` is high and `pc_out` is {second byte, first byte}.
- R5: An interrupt entry writes PC high, then PC low, then the status byte, decrementing after each write. The next cycle pulses `set_idis` and the cycle after that pulses `vec_req`.
- R6: On interrupt entry the stored status has bit 4 set when `brk` is 1 and bit 4 cleared when `brk` is 0. The other bits are unchanged. Push-status stores `stat_in` unchanged.
- R7: An interrupt return reads the status byte first (`stat_load`), then PC low, then PC high (`pc_load`). Each read is at a pre-incremented pointer.
- R8: Push-accumulator writes `acc_in` at the pointer and decrements. Pull-accumulator reads at pointer+1 with `acc_load` and increments. Pull-status does the same with `stat_load`.
- R9: `busy` rises in the cycle after a request is accepted and stays high through the last cycle of the sequence. A sequence runs for 2 cycles (call, return), 5 (interrupt entry), 3 (interrupt return) or 1 (each single-byte transfer). Requests that arrive while busy are ignored.
- R10: The pointer wraps modulo 256 within the selected page. A decrement from 0x00 gives 0xFF and an increment from 0xFF gives 0x00.
- R11: `req` bit mapping: bit 0 call, bit 1 return, bit 2 interrupt entry, bit 3 interrupt return, bit 4 push-accumulator, bit 5 pull-accumulator, bit 6 push-status, bit 7 pull-status. A request with more than one bit set is ignored, and the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 8 | One-hot stack request |
| brk | input | 1 | Interrupt entry comes from a software break |
| page_sel | input | 1 | Stack page select |
| pc_in | input | 16 | Return address to push |
| acc_in | input | 8 | Accumulator value to push |
| stat_in | input | 8 | Status value to push |
| mem_rdata | input | 8 | Memory read data (combinational) |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| pc_load | output | 1 | `pc_out` valid |
| pc_out | output | 16 | Popped return address |
| acc_load | output | 1 | `acc_out` valid |
| acc_out | output | 8 | Popped accumulator |
| stat_load | output | 1 | `stat_out` valid |
| stat_out | output | 8 | Popped status |
| set_idis | output | 1 | Request to set the interrupt-disable flag |
| vec_req | output | 1 | Request to fetch the interrupt vector |
| sp | output | 8 | Current stack pointer |

## Verification
The page-address assertion assumes `page_sel` holds steady for the whole of a sequence, because the address is formed from its live value. The stimulus changes the page only while the block is idle.

The pointer-step assertions assume that any access is a complete one-cycle transaction. Memory data is taken as valid combinationally in the read cycle, and the bench models its memory that way.

The stimulus also sends two deliberate protocol violations: a multi-bit request, and a request raised while busy. Both must leave the strobes and the pointer untouched.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_CALL, OP_RET, OP_IRQ, OP_RTI, OP_PHA, OP_PLA, OP_PHP, OP_PLP
    } seq_op_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST, ST_PUSH_A,
        ST_POP_ST, ST_POP_LO, ST_POP_HI, ST_POP_A, ST_SET_I, ST_VECTOR
    } seq_state_t;

    localparam int NUM_OPS = 8;

endpackage

// File: rtl/stack_req_decode.sv
module stack_req_decode
    import stack_seq_pkg::*;
#(
    parameter int N_REQ = NUM_OPS
) (
    input  logic [N_REQ-1:0] req,
    output logic             valid,
    output seq_op_t          op
);
    always_comb begin
        op    = OP_CALL;
        valid = (req != '0) && $onehot(req);
        for (int i = 0; i < N_REQ; i++) begin
            if (req[i]) op = seq_op_t'(i);
        end
    end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec,
    input  logic              inc,
    input  logic              page,
    output logic [PTR_W-1:0]  sp,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr
);
    localparam int HI_PAD = ADDR_W - PTR_W - 1;

    always_ff @(posedge clk) begin
        if (rst)      sp <= '1;
        else if (dec) sp <= sp - PTR_W'(1);
        else if (inc) sp <= sp + PTR_W'(1);
    end

    always_comb begin
        push_addr = {{HI_PAD{1'b0}}, page, sp};
        pop_addr  = {{HI_PAD{1'b0}}, page, sp + PTR_W'(1)};
    end

    // R10: wrap in both directions
    p_wrap_down_r10: assert property (@(posedge clk) disable iff (rst)
        (dec && sp == '0) |=> sp == '1);
    p_wrap_up_r10: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && sp == '1) |=> sp == '0);
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int BRK_BIT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_OPS-1:0]  req,
    input  logic                brk,
    input  logic                page_sel,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   stat_in,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                mem_we,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                pc_load,
    output logic [2*DATA_W-1:0] pc_out,
    output logic                acc_load,
    output logic [DATA_W-1:0]   acc_out,
    output logic                stat_load,
    output logic [DATA_W-1:0]   stat_out,
    output logic                set_idis,
    output logic                vec_req,
    output logic [PTR_W-1:0]    sp
);
    localparam int PC_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] BRK_MASK = DATA_W'(1) << BRK_BIT;

    seq_state_t state, nxt;
    seq_op_t    op_d, op_q;
    logic       req_ok, accept, sp_dec, sp_inc;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] acc_q, st_q, lo_q;
    logic [ADDR_W-1:0] push_addr, pop_addr;

    stack_req_decode #(.N_REQ(NUM_OPS)) u_dec (
        .req(req), .valid(req_ok), .op(op_d)
    );

    stack_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_sp (
        .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .page(page_sel),
        .sp(sp), .push_addr(push_addr), .pop_addr(pop_addr)
    );

    assign accept = (state == ST_IDLE) && req_ok;

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= OP_CALL;
            pc_q  <= '0;
            acc_q <= '0;
            st_q  <= '0;
            lo_q  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                op_q  <= op_d;
                pc_q  <= pc_in;
                acc_q <= acc_in;
                if (op_d == OP_IRQ)
                    st_q <= brk ? (stat_in | BRK_MASK) : (stat_in & ~BRK_MASK);
                else
                    st_q <= stat_in;
            end
            if (state == ST_POP_LO) lo_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_d)
                        OP_CALL, OP_IRQ: nxt = ST_PUSH_HI;
                        OP_RET:          nxt = ST_POP_LO;
                        OP_RTI, OP_PLP:  nxt = ST_POP_ST;
                        OP_PHA:          nxt = ST_PUSH_A;
                        OP_PHP:          nxt = ST_PUSH_ST;
                        OP_PLA:          nxt = ST_POP_A;
                        default:         nxt = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_HI: nxt = ST_PUSH_LO;
            ST_PUSH_LO: nxt = (op_q == OP_IRQ) ? ST_PUSH_ST : ST_IDLE;
            ST_PUSH_ST: nxt = (op_q == OP_IRQ) ? ST_SET_I : ST_IDLE;
            ST_SET_I:   nxt = ST_VECTOR;
            ST_POP_ST:  nxt = (op_q == OP_RTI) ? ST_POP_LO : ST_IDLE;
            ST_POP_LO:  nxt = ST_POP_HI;
            ST_VECTOR, ST_POP_HI, ST_POP_A, ST_PUSH_A: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        acc_load  = 1'b0;
        stat_load = 1'b0;
        set_idis  = 1'b0;
        vec_req   = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (state)
            ST_PUSH_HI: begin
                mem_we = 1'b1; mem_addr = push_addr; sp_dec = 1'b1;
                mem_wdata = pc_q[PC_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                mem_we = 1'b1; mem_addr = push_addr; sp_dec = 1'b1;
                mem_wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_ST: begin
                mem_we = 1'b1; mem_addr = push_addr; sp_dec = 1'b1;
                mem_wdata = st_q;
            end
            ST_PUSH_A: begin
                mem_we = 1'b1; mem_addr = push_addr; sp_dec = 1'b1;
                mem_wdata = acc_q;
            end
            ST_POP_ST: begin
                mem_re = 1'b1; mem_addr = pop_addr; sp_inc = 1'b1;
                stat_load = 1'b1;
            end
            ST_POP_LO: begin
                mem_re = 1'b1; mem_addr = pop_addr; sp_inc = 1'b1;
            end
            ST_POP_HI: begin
                mem_re = 1'b1; mem_addr = pop_addr; sp_inc = 1'b1;
                pc_load = 1'b1;
            end
            ST_POP_A: begin
                mem_re = 1'b1; mem_addr = pop_addr; sp_inc = 1'b1;
                acc_load = 1'b1;
            end
            ST_SET_I:  set_idis = 1'b1;
            ST_VECTOR: vec_req  = 1'b1;
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign pc_out   = {mem_rdata, lo_q};
    assign acc_out  = mem_rdata;
    assign stat_out = mem_rdata;

    // R1: reset state
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sp == '1 && !busy && !mem_we && !mem_re));
    // R2: address page
    p_page_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |->
        (mem_addr[ADDR_W-1:PTR_W+1] == '0 && mem_addr[PTR_W] == page_sel));
    // R3: every write steps the pointer down by one
    p_push_dec_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sp == $past(sp) - PTR_W'(1));
    // R4: every read steps the pointer up by one
    p_pop_inc_r4: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> sp == $past(sp) + PTR_W'(1));
    // R4: the return address is loaded in a read that follows another read
    p_pcload_r4: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> ($past(mem_re) && mem_re));
    // R5: vector request directly follows the disable-flag request
    p_vec_after_seti_r5: assert property (@(posedge clk) disable iff (rst)
        set_idis |=> (vec_req && !mem_we && !mem_re));
    // R9: accepted request makes the block busy
    p_busy_accept_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    // R9: one access at a time
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    // R11: malformed requests leave the block idle
    p_multi_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$onehot0(req)) |=> (!busy && $stable(sp)));
endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req = '0;
    logic        brk = 1'b0;
    logic        page_sel = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  acc_in = '0, stat_in = '0;
    logic [7:0]  mem_rdata;
    logic        busy, mem_we, mem_re, pc_load, acc_load, stat_load, set_idis, vec_req;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, acc_out, stat_out, sp;

    always #5 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst(rst), .req(req), .brk(brk), .page_sel(page_sel),
        .pc_in(pc_in), .acc_in(acc_in), .stat_in(stat_in), .mem_rdata(mem_rdata),
        .busy(busy), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_out(pc_out),
        .acc_load(acc_load), .acc_out(acc_out), .stat_load(stat_load),
        .stat_out(stat_out), .set_idis(set_idis), .vec_req(vec_req), .sp(sp)
    );

    // bench memory, combinational read
    logic [7:0] mem [0:511];
    assign mem_rdata = mem[mem_addr[8:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;

    int n_chk = 0, n_bad = 0;
    typedef struct { int kind; logic [15:0] addr; logic [7:0] data; string tag; } item_t;
    item_t exp_q[$];
    logic [15:0] last_pc;
    logic [7:0]  last_acc, last_stat;
    logic [7:0]  m_sp;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, logic [15:0] addr, logic [7:0] data, string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.data = data; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compares every strobe against the scoreboard queue
    task automatic got_ev(int kind, logic [15:0] addr, logic [7:0] data);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event (R9/R11)", kind, -1);
        end else begin
            it = exp_q.pop_front();
            check(it.kind == kind, {it.tag, " kind"}, kind, it.kind);
            if (kind < 2) check(it.addr == addr, {it.tag, " addr"}, addr, it.addr);
            if (kind == 0) check(it.data == data, {it.tag, " data"}, data, it.data);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we)   got_ev(0, mem_addr, mem_wdata);
            if (mem_re)   got_ev(1, mem_addr, 8'h00);
            if (set_idis) got_ev(2, '0, '0);
            if (vec_req)  got_ev(3, '0, '0);
            if (pc_load)   last_pc   = pc_out;
            if (acc_load)  last_acc  = acc_out;
            if (stat_load) last_stat = stat_out;
        end
    end

    function automatic logic [15:0] a_of(logic [7:0] p);
        return {7'b0, page_sel, p};
    endfunction

    // driver: one request, wait for completion, check busy length and pointer
    task automatic run_op(logic [7:0] r, int exp_len, string tag);
        int n;
        @(negedge clk);
        req = r;
        @(negedge clk);
        req = '0;
        n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_len, {tag, " busy length (R9)"}, n, exp_len);
        check(sp == m_sp, {tag, " pointer"}, sp, m_sp);
    endtask

    task automatic do_call(logic [15:0] pc, string tag);
        pc_in = pc;
        expect_ev(0, a_of(m_sp), pc[15:8], {tag, " R3 hi"});
        expect_ev(0, a_of(m_sp - 8'd1), pc[7:0], {tag, " R3 lo"});
        m_sp = m_sp - 8'd2;
        run_op(8'h01, 2, tag);
    endtask

    task automatic do_ret(string tag);
        logic [15:0] e;
        e = {mem[{page_sel, m_sp + 8'd2}], mem[{page_sel, m_sp + 8'd1}]};
        expect_ev(1, a_of(m_sp + 8'd1), 0, {tag, " R4 lo"});
        expect_ev(1, a_of(m_sp + 8'd2), 0, {tag, " R4 hi"});
        m_sp = m_sp + 8'd2;
        run_op(8'h02, 2, tag);
        check(last_pc == e, {tag, " R4 pc_out"}, last_pc, e);
    endtask

    task automatic do_irq(logic [15:0] pc, logic [7:0] st, logic b, string tag);
        logic [7:0] es;
        pc_in = pc; stat_in = st; brk = b;
        es = b ? (st | 8'h10) : (st & 8'hEF);
        expect_ev(0, a_of(m_sp), pc[15:8], {tag, " R5 hi"});
        expect_ev(0, a_of(m_sp - 8'd1), pc[7:0], {tag, " R5 lo"});
        expect_ev(0, a_of(m_sp - 8'd2), es, {tag, " R6 status"});
        expect_ev(2, '0, '0, {tag, " R5 set_idis"});
        expect_ev(3, '0, '0, {tag, " R5 vec_req"});
        m_sp = m_sp - 8'd3;
        run_op(8'h04, 5, tag);
        brk = 1'b0;
    endtask

    task automatic do_rti(string tag);
        logic [7:0] es; logic [15:0] ep;
        es = mem[{page_sel, m_sp + 8'd1}];
        ep = {mem[{page_sel, m_sp + 8'd3}], mem[{page_sel, m_sp + 8'd2}]};
        expect_ev(1, a_of(m_sp + 8'd1), 0, {tag, " R7 st"});
        expect_ev(1, a_of(m_sp + 8'd2), 0, {tag, " R7 lo"});
        expect_ev(1, a_of(m_sp + 8'd3), 0, {tag, " R7 hi"});
        m_sp = m_sp + 8'd3;
        run_op(8'h08, 3, tag);
        check(last_stat == es, {tag, " R7 stat_out"}, last_stat, es);
        check(last_pc == ep, {tag, " R7 pc_out"}, last_pc, ep);
    endtask

    task automatic do_push(bit is_stat, logic [7:0] v, string tag);
        if (is_stat) stat_in = v; else acc_in = v;
        expect_ev(0, a_of(m_sp), v, {tag, " R8 push"});
        m_sp = m_sp - 8'd1;
        run_op(is_stat ? 8'h40 : 8'h10, 1, tag);
    endtask

    task automatic do_pull(bit is_stat, string tag);
        logic [7:0] e;
        e = mem[{page_sel, m_sp + 8'd1}];
        expect_ev(1, a_of(m_sp + 8'd1), 0, {tag, " R8 pull"});
        m_sp = m_sp + 8'd1;
        run_op(is_stat ? 8'h80 : 8'h20, 1, tag);
        if (is_stat) check(last_stat == e, {tag, " R8 stat_out"}, last_stat, e);
        else         check(last_acc == e, {tag, " R8 acc_out"}, last_acc, e);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(sp == 8'hFF, "R1 sp", sp, 8'hFF);
        check(!busy && !mem_we && !mem_re && !set_idis && !vec_req, "R1 idle", busy, 0);
        m_sp = 8'hFF;

        // R2, R3, R4 on page 0
        do_call(16'h1234, "call p0");
        do_ret("ret p0");
        // R2 page 1, R5, R6 (hardware entry clears bit 4), R7
        page_sel = 1'b1;
        do_call(16'hBEEF, "call p1");
        do_irq(16'hC0DE, 8'h5A, 1'b0, "irq hw");
        do_rti("rti hw");
        // R6 software break sets bit 4
        do_irq(16'h0F0F, 8'h00, 1'b1, "irq brk");
        do_rti("rti brk");
        do_ret("ret p1");
        // R8 single-byte transfers
        page_sel = 1'b0;
        do_push(1'b0, 8'hA5, "pha");
        do_push(1'b1, 8'h3C, "php");
        do_pull(1'b1, "plp");
        do_pull(1'b0, "pla");
        check(m_sp == 8'hFF, "R8 balance", m_sp, 8'hFF);
        // R10: increment from FF wraps to 00, then decrement below 00 wraps
        do_pull(1'b0, "pla wrap R10");
        check(sp == 8'h00, "R10 up-wrap", sp, 0);
        do_call(16'h5678, "call wrap R10");
        check(sp == 8'hFE, "R10 down-wrap", sp, 8'hFE);
        do_ret("ret wrap R10");
        do_push(1'b0, 8'h77, "pha wrap R10");

        // R11: multi-bit request ignored
        @(negedge clk);
        req = 8'h03;
        @(negedge clk);
        req = '0;
        check(!busy, "R11 busy", busy, 0);
        @(negedge clk);
        check(sp == m_sp, "R11 sp unchanged", sp, m_sp);

        // R9: request while busy is ignored
        pc_in = 16'h2468;
        expect_ev(0, a_of(m_sp), 8'h24, "busy R9 hi");
        expect_ev(0, a_of(m_sp - 8'd1), 8'h68, "busy R9 lo");
        m_sp = m_sp - 8'd2;
        req = 8'h01;
        @(negedge clk);
        req = 8'h10;
        @(negedge clk);
        req = '0;
        repeat (3) @(negedge clk);
        check(!busy, "R9 done", busy, 0);
        check(sp == m_sp, "R9 sp after ignored req", sp, m_sp);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule